// File: doc/BRIEF.md
# Special Capability Register Access Port

This block stores the special capability registers that live outside the general capability register file, and it answers the two instructions that copy one of them to a general register or load one of them from a general register. Each request carries a 5-bit selector. A read request returns the selected register's value in the same cycle. A write request stores the supplied capability at the next clock edge. Storage is eight separate registers reached through a sparse selector map. The path never uses a general-file index, so selector 0 here means the default data capability itself and not a general register.

A permission bit is taken from the current program-counter capability. It decides which selectors a request may touch. A request that lacks permission raises an access-violation exception and reports the offending selector, and the access does not happen. A selector outside the map raises an internal-error flag and also does nothing. Capability words are opaque: a tag bit on top of a data field, copied unchanged.

Top module: `special_cap_port`

## Requirements
- R1: After reset, selectors 0 (default data), 29 (kernel code) and 31 (exception PC) hold the default capability, which is all CAP_W bits set to 1. Selectors 1, 8, 22, 23 and 30 hold the null capability, which is all zero.
- R2: A permitted read request (reqValid=1, reqWrite=0) returns the register that its selector maps to on rdData in the same cycle. The map is: 0 default data, 1 user thread-local, 8 privileged thread-local, 22 kernel reserved 1, 23 kernel reserved 2, 29 kernel code, 30 kernel data, 31 exception PC.
- R3: A permitted write request (reqValid=1, reqWrite=1) stores wrData into the mapped register at the next rising clock edge. The value can be read back from the following cycle, and no other register changes.
- R4: A request with a selector outside the map sets badSel=1 in that cycle and leaves denyExc=0. A write changes no register, and rdData is 0.
- R5: Selectors 0 and 1 can be read and written with sysPerm=0.
- R6: A request to any other mapped selector with sysPerm=0 sets denyExc=1 and denySel to the selector in that cycle. The register is not written, and rdData is 0.
- R7: With reqValid=0, badSel and denyExc are 0, rdData is 0 and no register changes, whatever the other inputs are.
- R8: All CAP_W bits pass through unchanged in both directions, including the tag in bit CAP_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 5 | Special register selector |
| wrData | input | CAP_W | Capability to store |
| sysPerm | input | 1 | System-register permission from the program-counter capability |
| rdData | output | CAP_W | Read result, 0 unless a permitted read |
| denyExc | output | 1 | Access-violation exception |
| denySel | output | 5 | Selector that caused the exception |
| badSel | output | 1 | Unmapped selector error |

## Verification
The flags badSel, denyExc and denySel and the read data are combinational, so they are due in the cycle of the request. The bench drives each request just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. A write commits at the rising edge that follows, so the bench checks a write, or its suppression, by reading in the next low phase. That read keeps reqValid high and comes before any later request.

// File: rtl/spcap_pkg.sv
package spcap_pkg;

  localparam int SEL_W     = 5;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_DDC  = 3'd0,
    SLOT_TLSU = 3'd1,
    SLOT_TLSP = 3'd2,
    SLOT_KR1  = 3'd3,
    SLOT_KR2  = 3'd4,
    SLOT_KCC  = 3'd5,
    SLOT_KDC  = 3'd6,
    SLOT_EPCC = 3'd7
  } slot_e;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] wrHot;
    logic                 rdHit;
    slot_e                rdSlot;
  } strobe_t;

  function automatic logic slotResetsDefault(int s);
    return (s == int'(SLOT_DDC)) || (s == int'(SLOT_KCC)) || (s == int'(SLOT_EPCC));
  endfunction

  function automatic logic slotIsOpen(slot_e s);
    return (s == SLOT_DDC) || (s == SLOT_TLSU);
  endfunction

endpackage

// File: rtl/spcap_ctrl.sv
module spcap_ctrl
  import spcap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [SEL_W-1:0] reqSel,
  input  logic             sysPerm,
  output strobe_t          strobes,
  output logic             denyExc,
  output logic [SEL_W-1:0] denySel,
  output logic             badSel
);

  logic  mapped;
  slot_e slot;
  logic  allowed;
  logic  grant;

  always_comb begin
    mapped = 1'b1;
    slot   = SLOT_DDC;
    unique case (reqSel)
      5'd0:    slot = SLOT_DDC;
      5'd1:    slot = SLOT_TLSU;
      5'd8:    slot = SLOT_TLSP;
      5'd22:   slot = SLOT_KR1;
      5'd23:   slot = SLOT_KR2;
      5'd29:   slot = SLOT_KCC;
      5'd30:   slot = SLOT_KDC;
      5'd31:   slot = SLOT_EPCC;
      default: mapped = 1'b0;
    endcase
  end

  assign allowed = slotIsOpen(slot) || sysPerm;
  assign grant   = reqValid && mapped && allowed;
  assign badSel  = reqValid && !mapped;
  assign denyExc = reqValid && mapped && !allowed;
  assign denySel = denyExc ? reqSel : '0;

  always_comb begin
    strobes        = '0;
    strobes.rdSlot = slot;
    strobes.rdHit  = grant && !reqWrite;
    if (grant && reqWrite) strobes.wrHot[slot] = 1'b1;
  end

  AST_OPEN_SEL_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqSel == 5'd0 || reqSel == 5'd1)) |-> !denyExc) else $error("open selector denied"); // R5
  AST_DENY_BLOCKS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    denyExc |-> (strobes.wrHot == '0 && !strobes.rdHit)) else $error("denied access strobed"); // R6
  AST_BAD_SEL_NO_EXC: assert property (@(posedge clk) disable iff (!rstN)
    badSel |-> (!denyExc && strobes.wrHot == '0)) else $error("bad selector acted"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!badSel && !denyExc && strobes == '{default:'0, rdSlot:slot})) else $error("idle activity"); // R7

endmodule

// File: rtl/spcap_regs.sv
module spcap_regs
  import spcap_pkg::*;
#(
  parameter int               CAP_W   = 129,
  parameter logic [CAP_W-1:0] DEF_CAP = {CAP_W{1'b1}}
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [CAP_W-1:0] wrData,
  output logic [CAP_W-1:0] rdData
);

  logic [NUM_SLOTS-1:0][CAP_W-1:0] store;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [CAP_W-1:0] RST_VAL = slotResetsDefault(i) ? DEF_CAP : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 store[i] <= RST_VAL;
      else if (strobes.wrHot[i]) store[i] <= wrData;
    end

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrHot[i] |=> $stable(store[i])) else $error("slot changed unstrobed"); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrHot[i] |=> (store[i] == $past(wrData))) else $error("write lost"); // R8
  end

  assign rdData = strobes.rdHit ? store[strobes.rdSlot] : '0;

  AST_ONE_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrHot)) else $error("multiple write strobes"); // R3

endmodule

// File: rtl/special_cap_port.sv
module special_cap_port
  import spcap_pkg::*;
#(
  parameter int               CAP_W   = 129,
  parameter logic [CAP_W-1:0] DEF_CAP = {CAP_W{1'b1}}
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [4:0]       reqSel,
  input  logic [CAP_W-1:0] wrData,
  input  logic             sysPerm,
  output logic [CAP_W-1:0] rdData,
  output logic             denyExc,
  output logic [4:0]       denySel,
  output logic             badSel
);

  strobe_t strobes;

  spcap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .sysPerm(sysPerm), .strobes(strobes),
    .denyExc(denyExc), .denySel(denySel), .badSel(badSel)
  );

  spcap_regs #(.CAP_W(CAP_W), .DEF_CAP(DEF_CAP)) i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );

  AST_FAULT_READS_NULL: assert property (@(posedge clk) disable iff (!rstN)
    (denyExc || badSel) |-> (rdData == '0)) else $error("fault leaked data"); // R6
  AST_DENY_SEL_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    denyExc |-> (denySel == reqSel && reqSel != 5'd0 && reqSel != 5'd1)) else $error("bad deny selector"); // R6

endmodule

// File: tb/test_special_cap_port.sv
module test_special_cap_port;
  localparam int CAP_W = 129;
  localparam logic [CAP_W-1:0] DEF = {CAP_W{1'b1}};

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, sysPerm = 0;
  logic [4:0] reqSel = 0;
  logic [CAP_W-1:0] wrData = 0, rdData;
  logic denyExc, badSel;
  logic [4:0] denySel;

  int errors = 0, checks = 0;
  logic [CAP_W-1:0] mdl [8];
  int sels [8] = '{0, 1, 8, 22, 23, 29, 30, 31};

  always #4 clk = ~clk;

  special_cap_port #(.CAP_W(CAP_W)) i_special_cap_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqSel(reqSel),
    .wrData(wrData), .sysPerm(sysPerm), .rdData(rdData), .denyExc(denyExc),
    .denySel(denySel), .badSel(badSel)
  );

  task automatic chk(string req, logic [CAP_W-1:0] act, logic [CAP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CAP_W-1:0] pat(int i, logic tag);
    logic [31:0] w = 32'(i) * 32'h1111_1111 ^ 32'hC0DE_0000;
    return {tag, w, ~w, w ^ 32'h5A5A_5A5A, w + 32'd7};
  endfunction

  task automatic readSel(int sel, logic perm, output logic [CAP_W-1:0] d,
                         output logic dx, output logic [4:0] ds, output logic bs);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqSel = 5'(sel); sysPerm = perm;
    #1; d = rdData; dx = denyExc; ds = denySel; bs = badSel;
    reqValid = 0;
  endtask

  task automatic writeSel(int sel, logic perm, logic [CAP_W-1:0] v,
                          output logic dx, output logic [4:0] ds, output logic bs);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqSel = 5'(sel); sysPerm = perm; wrData = v;
    #1; dx = denyExc; ds = denySel; bs = badSel;
    @(posedge clk); #1;
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic checkAll(string req);
    logic [CAP_W-1:0] d; logic dx, bs; logic [4:0] ds;
    for (int k = 0; k < 8; k++) begin
      readSel(sels[k], 1'b1, d, dx, ds, bs);
      chk(req, d, mdl[k]);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) mdl[k] = (k == 0 || k == 5 || k == 7) ? DEF : '0;
    checkAll("R1 reset value");
  endtask

  task automatic t_open();
    logic [CAP_W-1:0] d; logic dx, bs; logic [4:0] ds;
    for (int k = 0; k < 2; k++) begin
      writeSel(sels[k], 1'b0, pat(40 + k, 1'b1), dx, ds, bs);
      chk("R5 open write no exc", CAP_W'(dx), '0);
      mdl[k] = pat(40 + k, 1'b1);
      readSel(sels[k], 1'b0, d, dx, ds, bs);
      chk("R5 open read data", d, mdl[k]);
      chk("R5 open read no exc", CAP_W'(dx), '0);
    end
  endtask

  task automatic t_deny();
    logic [CAP_W-1:0] d; logic dx, bs; logic [4:0] ds;
    for (int k = 2; k < 8; k++) begin
      writeSel(sels[k], 1'b0, pat(90 + k, 1'b0), dx, ds, bs);
      chk("R6 write exc", CAP_W'(dx), 1);
      chk("R6 write denySel", CAP_W'(ds), CAP_W'(sels[k]));
      readSel(sels[k], 1'b0, d, dx, ds, bs);
      chk("R6 read exc", CAP_W'(dx), 1);
      chk("R6 read null", d, '0);
    end
    checkAll("R6 suppressed write");
  endtask

  task automatic t_writeAll();
    for (int k = 0; k < 8; k++) begin
      logic dx, bs; logic [4:0] ds;
      writeSel(sels[k], 1'b1, pat(k, k[0]), dx, ds, bs);
      chk("R3 permitted write flags", CAP_W'({dx, bs}), '0);
      mdl[k] = pat(k, k[0]);
      checkAll("R3 R2 R8 readback");
    end
  endtask

  task automatic t_illegal();
    int bad [6] = '{2, 7, 9, 21, 24, 28};
    logic [CAP_W-1:0] d; logic dx, bs; logic [4:0] ds;
    foreach (bad[j]) begin
      writeSel(bad[j], 1'b1, pat(77, 1'b1), dx, ds, bs);
      chk("R4 write badSel", CAP_W'(bs), 1);
      chk("R4 write no exc", CAP_W'(dx), 0);
      readSel(bad[j], 1'b0, d, dx, ds, bs);
      chk("R4 read badSel", CAP_W'(bs), 1);
      chk("R4 read null", d, '0);
    end
    checkAll("R4 no state change");
  endtask

  task automatic t_idle();
    @(negedge clk);
    reqValid = 0; reqWrite = 1; reqSel = 5'd31; sysPerm = 1; wrData = pat(5, 1'b0) ^ DEF;
    #1;
    chk("R7 idle flags", CAP_W'({badSel, denyExc}), '0);
    chk("R7 idle rdData", rdData, '0);
    @(posedge clk); #1; reqWrite = 0;
    checkAll("R7 idle no write");
  endtask

  initial begin
    fork
      begin
        #20; rstN = 1;
        t_reset(); t_open(); t_deny(); t_writeAll(); t_illegal(); t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule